// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Sequencer

This block turns one PWM command into the two gate enables of a synchronous buck half-bridge. It does not count a fixed dead time. Each gate enable is raised only after a feedback flag reports that the opposite gate has discharged below its turn-off level. The PWM command arrives already decoded into a 2-bit code with three meanings: high, low and shutdown. A supply-good flag from an external power-on detector gates all switching.

A mode pin selects between two behaviours. With the pin high the stage runs in forced continuous conduction. With the pin low the low side may be cut off early (diode emulation): when the inductor zero-current flag is seen, and only after a minimum low-side on-time, both gates stay off until the command returns high. Each interlock wait also has a watchdog. If a feedback flag never arrives, the fault output is raised and both gates are kept off.

The FSM states are:
- IDLE: both off, waiting for a valid level.
- HS_WAIT: high side requested, waiting for the low gate to fall.
- HS_ON: high side on.
- LS_WAIT: low side requested, waiting for the high gate to fall.
- LS_ON: low side on.
- DCM_OFF: low side cut off by a zero crossing.
- FAULT: a feedback flag never arrived.

The transitions are:
- IDLE to HS_WAIT on a high code, and IDLE to LS_WAIT on a low code.
- HS_WAIT to HS_ON on the low-gate flag, HS_WAIT to LS_WAIT on a low code, and HS_WAIT to FAULT on timeout.
- HS_ON to LS_WAIT on a low code.
- LS_WAIT to LS_ON on the high-gate flag, LS_WAIT to HS_WAIT on a high code, and LS_WAIT to FAULT on timeout.
- LS_ON to HS_WAIT on a high code, and LS_ON to DCM_OFF on a qualified zero crossing.
- DCM_OFF to HS_WAIT on a high code.
- From any state to IDLE on a shutdown code or on loss of supply-good. This is the only way out of FAULT apart from reset.

Top module: `hb_deadtime_seq`

## Requirements
- R1: After a high code (`pwm_code` = 2'b01), `hs_en` rises only on a clock edge at which `ls_off_fb` is 1 and `ls_en` is already 0.
- R2: After a low code (`pwm_code` = 2'b00), `ls_en` rises only on a clock edge at which `hs_off_fb` is 1 and `hs_en` is already 0.
- R3: `hs_en` and `ls_en` are never 1 in the same cycle.
- R4: With `force_ccm` = 0, a zero-current flag seen during low-side conduction drops `ls_en`. Both enables then stay 0 while the code stays low, even after `zero_cross` clears.
- R5: With `force_ccm` = 1, `zero_cross` has no effect: `ls_en` stays 1 while the code is low.
- R6: A change of `force_ccm` acts on the next clock edge. Lowering it while `zero_cross` is 1 and the minimum on-time has passed drops `ls_en` one cycle later.
- R7: In diode-emulation mode, `ls_en` stays high for exactly MIN_LS_ON_CYC cycles when `zero_cross` is already 1 at turn-on.
- R8: Codes 2'b10 and 2'b11 mean shutdown. One cycle after either code is seen, both enables are 0.
- R9: One cycle after `supply_ok` is seen at 0, both enables and `fault` are 0.
- R10: Leaving shutdown or supply loss, no enable rises before a valid code. A first low code still waits for `hs_off_fb` before raising `ls_en`.
- R11: If a wait state lasts WAIT_LIMIT cycles without its flag, `fault` rises on that edge. Both enables then stay 0 and `fault` stays 1 until a shutdown code or supply loss.
- R12: During and right after reset, `hs_en`, `ls_en` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_code | input | 2 | Decoded command: 00 low, 01 high, 10/11 shutdown |
| hs_off_fb | input | 1 | High-side gate is below its turn-off level |
| ls_off_fb | input | 1 | Low-side gate is below its turn-off level |
| zero_cross | input | 1 | Inductor current has reached zero |
| force_ccm | input | 1 | 1 forces continuous conduction, 0 allows diode emulation |
| supply_ok | input | 1 | Supply above its power-on level |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| fault | output | 1 | An interlock feedback flag timed out |

## Verification
The embedded assertions check the following on every cycle:
- the enables never overlap;
- each enable rises only on an edge where the opposite gate's flag was present;
- shutdown and supply loss clear the outputs one cycle later;
- continuous mode keeps the low side on while the code stays low.

Some behaviours are shown only by the bench scenarios, because they depend on how long things last:
- the exact length of the minimum low-side on-time;
- the gates staying off after a diode-emulation cutoff;
- the immediate effect of the mode pin;
- the watchdog trip cycle and the stickiness of the fault.

The bench drives the feedback flags from a delay model of each gate discharging, so the interlock is exercised against realistic flag timing.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    // Command codes; both upper codes mean shutdown.
    localparam logic [1:0] CMD_LOW  = 2'b00;
    localparam logic [1:0] CMD_HIGH = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HS_WAIT = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_LS_WAIT = 3'd3,
        ST_LS_ON   = 3'd4,
        ST_DCM_OFF = 3'd5,
        ST_FAULT   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode (
    input  logic [1:0] code,
    output logic       want_high,
    output logic       want_low,
    output logic       stop
);
    import hb_seq_pkg::*;

    always_comb begin
        want_high = (code == CMD_HIGH);
        want_low  = (code == CMD_LOW);
        stop      = code[1];
    end
endmodule

// File: rtl/hb_dwell_counter.sv
module hb_dwell_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Counts the cycles spent in one state; saturates at LIMIT-1, clears when idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq #(
    parameter int MIN_LS_ON_CYC = 40,
    parameter int WAIT_LIMIT    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_code,
    input  logic       hs_off_fb,
    input  logic       ls_off_fb,
    input  logic       zero_cross,
    input  logic       force_ccm,
    input  logic       supply_ok,
    output logic       hs_en,
    output logic       ls_en,
    output logic       fault
);
    import hb_seq_pkg::*;

    seq_state_e state, nxt;
    logic want_high, want_low, stop;
    logic hs_wait_exp, ls_wait_exp, min_on_done;

    hb_cmd_decode u_dec (
        .code      (pwm_code),
        .want_high (want_high),
        .want_low  (want_low),
        .stop      (stop)
    );

    // One dwell timer per interlock wait, plus the low-side minimum on-time.
    hb_dwell_counter #(.LIMIT(WAIT_LIMIT)) u_hs_wd (
        .clk (clk), .rst_n (rst_n),
        .run (state == ST_HS_WAIT), .expired (hs_wait_exp)
    );
    hb_dwell_counter #(.LIMIT(WAIT_LIMIT)) u_ls_wd (
        .clk (clk), .rst_n (rst_n),
        .run (state == ST_LS_WAIT), .expired (ls_wait_exp)
    );
    hb_dwell_counter #(.LIMIT(MIN_LS_ON_CYC)) u_min_on (
        .clk (clk), .rst_n (rst_n),
        .run (state == ST_LS_ON), .expired (min_on_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (stop || !supply_ok) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (want_high)     nxt = ST_HS_WAIT;
                    else if (want_low) nxt = ST_LS_WAIT;
                end
                ST_HS_WAIT: begin
                    if (want_low)         nxt = ST_LS_WAIT;
                    else if (ls_off_fb)   nxt = ST_HS_ON;
                    else if (hs_wait_exp) nxt = ST_FAULT;
                end
                ST_HS_ON: begin
                    if (want_low) nxt = ST_LS_WAIT;
                end
                ST_LS_WAIT: begin
                    if (want_high)        nxt = ST_HS_WAIT;
                    else if (hs_off_fb)   nxt = ST_LS_ON;
                    else if (ls_wait_exp) nxt = ST_FAULT;
                end
                ST_LS_ON: begin
                    if (want_high)
                        nxt = ST_HS_WAIT;
                    else if (!force_ccm && zero_cross && min_on_done)
                        nxt = ST_DCM_OFF;
                end
                ST_DCM_OFF: begin
                    if (want_high) nxt = ST_HS_WAIT;
                end
                ST_FAULT: nxt = ST_FAULT;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        hs_en = (state == ST_HS_ON);
        ls_en = (state == ST_LS_ON);
        fault = (state == ST_FAULT);
    end

    // R3: enables are mutually exclusive.
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R1: high side rises only after low gate was reported low.
    a_r1_hs_after_ls_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(ls_off_fb) && !$past(ls_en)));

    // R2: low side rises only after high gate was reported low.
    a_r2_ls_after_hs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> ($past(hs_off_fb) && !$past(hs_en)));

    // R8: shutdown code clears both enables on the next cycle.
    a_r8_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_code[1] |=> (!hs_en && !ls_en));

    // R9: supply loss clears enables and fault.
    a_r9_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_en && !ls_en && !fault));

    // R5: in forced continuous mode the low side holds while the code stays low.
    a_r5_ccm_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en && force_ccm && supply_ok && pwm_code == CMD_LOW) |=> ls_en);
endmodule

// File: tb/tb_hb_deadtime_seq.sv
module tb_hb_deadtime_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_ON  = 6;
    localparam int WAIT_LIM = 5;
    localparam int HS_DLY = 2;
    localparam int LS_DLY = 3;
    localparam int NVEC = 18;

    // Row: pwm[9:8] hs_fb ls_fb zc fccm sup | exp hs ls fault
    localparam logic [10:0] VEC [NVEC] = '{
        11'b10_1_1_0_1_1_000, // R8 shutdown
        11'b01_1_0_0_1_1_000, // R1 wait for low gate
        11'b01_1_0_0_1_1_000, // R1 still waiting
        11'b01_1_1_0_1_1_100, // R1 high side on
        11'b01_0_1_0_1_1_100, // high side holds
        11'b00_0_1_0_1_1_000, // R2 wait for high gate
        11'b00_0_1_0_1_1_000, // R2 still waiting
        11'b00_1_1_0_1_1_010, // R2 low side on
        11'b00_1_0_1_1_1_010, // R5 zero cross ignored
        11'b00_1_0_1_1_1_010, // R5 zero cross ignored
        11'b01_1_0_0_1_1_000, // R1 low side dropped, waiting
        11'b01_1_1_0_1_1_100, // R1 high side on
        11'b10_0_1_0_1_1_000, // R8 shutdown
        11'b00_1_1_0_0_1_000, // R10 first low goes through wait
        11'b00_1_1_0_0_1_010, // R10 low side on
        11'b00_1_0_0_0_0_000, // R9 supply loss
        11'b00_1_1_0_1_1_000, // R10 wait after supply return
        11'b00_1_1_0_1_1_010  // R10 low side on
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] pwm_code = 2'b10;
    logic hs_fb_t = 1'b1, ls_fb_t = 1'b1;
    logic zero_cross = 1'b0, force_ccm = 1'b1, supply_ok = 1'b1;
    logic model_on = 1'b0;
    logic hs_off_fb, ls_off_fb;
    logic hs_en, ls_en, fault;
    int hs_cnt = 0, ls_cnt = 0;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_deadtime_seq #(.MIN_LS_ON_CYC(MIN_ON), .WAIT_LIMIT(WAIT_LIM)) dut (
        .clk (clk), .rst_n (rst_n), .pwm_code (pwm_code),
        .hs_off_fb (hs_off_fb), .ls_off_fb (ls_off_fb),
        .zero_cross (zero_cross), .force_ccm (force_ccm), .supply_ok (supply_ok),
        .hs_en (hs_en), .ls_en (ls_en), .fault (fault)
    );

    // Gate discharge model: flag rises a fixed delay after the enable drops.
    always @(negedge clk) begin
        if (hs_en) hs_cnt <= 0; else if (hs_cnt < HS_DLY) hs_cnt <= hs_cnt + 1;
        if (ls_en) ls_cnt <= 0; else if (ls_cnt < LS_DLY) ls_cnt <= ls_cnt + 1;
    end
    assign hs_off_fb = model_on ? (!hs_en && hs_cnt >= HS_DLY) : hs_fb_t;
    assign ls_off_fb = model_on ? (!ls_en && ls_cnt >= LS_DLY) : ls_fb_t;

    // R3 overlap monitor
    always @(negedge clk) begin
        if (rst_n && hs_en && ls_en) begin
            n_fail++;
            $display("FAIL R3 overlap: hs=%0b ls=%0b expected not both 1", hs_en, ls_en);
        end
    end

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got hs/ls/fault=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        bit seen;
        // R12 reset state
        repeat (3) @(negedge clk);
        check("R12 in reset", {hs_en, ls_en, fault}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset", {hs_en, ls_en, fault}, 3'b000);

        for (int i = 0; i < NVEC; i++) begin
            {pwm_code, hs_fb_t, ls_fb_t, zero_cross, force_ccm, supply_ok} = VEC[i][10:3];
            @(negedge clk);
            check($sformatf("table row %0d (R1/R2/R5/R8/R9/R10)", i),
                  {hs_en, ls_en, fault}, VEC[i][2:0]);
        end

        // R7 / R4: diode emulation with the gate model
        pwm_code = 2'b10; supply_ok = 1'b1; model_on = 1'b1;
        force_ccm = 1'b0; zero_cross = 1'b1;
        repeat (2) @(negedge clk);
        pwm_code = 2'b00;
        seen = 0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(negedge clk);
            if (ls_en) seen = 1;
        end
        check("R2 low side reached via model", {2'b00, seen}, 3'b001);
        cnt = 0;
        while (ls_en && cnt < 50) begin
            cnt++;
            @(negedge clk);
        end
        n_run++;
        if (cnt != MIN_ON) begin
            n_fail++;
            $display("FAIL R7 min on-time: got %0d cycles expected %0d", cnt, MIN_ON);
        end
        zero_cross = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R4 stays off after cutoff", {hs_en, ls_en, fault}, 3'b000);
        end
        pwm_code = 2'b01;
        seen = 0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(negedge clk);
            if (hs_en) seen = 1;
        end
        check("R1 high side after cutoff", {2'b00, seen}, 3'b001);

        // R5 / R6: forced continuous then immediate mode change
        force_ccm = 1'b1; zero_cross = 1'b1; pwm_code = 2'b00;
        seen = 0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(negedge clk);
            if (ls_en) seen = 1;
        end
        repeat (MIN_ON + 4) @(negedge clk);
        check("R5 zero cross ignored in CCM", {hs_en, ls_en, fault}, 3'b010);
        force_ccm = 1'b0;
        @(negedge clk);
        check("R6 mode change immediate", {hs_en, ls_en, fault}, 3'b000);

        // R11 watchdog
        pwm_code = 2'b10; model_on = 1'b0; hs_fb_t = 1'b1; ls_fb_t = 1'b0;
        force_ccm = 1'b1; zero_cross = 1'b0;
        repeat (2) @(negedge clk);
        pwm_code = 2'b01;
        repeat (WAIT_LIM) @(negedge clk);
        check("R11 before timeout", {hs_en, ls_en, fault}, 3'b000);
        @(negedge clk);
        check("R11 timeout", {hs_en, ls_en, fault}, 3'b001);
        ls_fb_t = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 fault held", {hs_en, ls_en, fault}, 3'b001);
        pwm_code = 2'b11;
        @(negedge clk);
        check("R8 code 11 clears fault", {hs_en, ls_en, fault}, 3'b000);

        finish_run();
    end
endmodule